// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional

This block keeps the address reservations that make load-locked / store-conditional pairs atomic when several hardware contexts share one memory port. It sits beside the port and sees every request: the context ID, the byte address, the direction and a locked flag. A locked read places a reservation for the issuing context. A locked write is a store-conditional, and it is allowed to reach memory only if that context still holds a reservation on the same granule.

The table has one entry per context, so entry *i* belongs to context *i* and no context ID needs to be stored. An entry holds a valid bit and the granule part of the address. Every write is compared with all entries in the same cycle. Any write to a reserved granule drops every reservation on that granule, whichever context owns it. The write gate goes out combinationally in the cycle of the request. The store-conditional result is registered and appears one cycle later.

Top module: `lrsc_monitor`

## Requirements
- R1: A synchronous active-high reset clears every reservation, and no store-conditional response is presented in the cycle after reset.
- R2: A locked read (req_valid=1, req_write=0, req_locked=1) from a context reserves its granule, and a later store-conditional from the same context to that granule passes.
- R3: A context holds at most one reservation. A new locked read from it moves the reservation to the new granule, so a store-conditional to the old granule then fails.
- R4: Addresses are compared by granule only: bits [GRAN_LSB-1:0] (default 3, so an 8-byte granule) are ignored, and addresses in different granules never match.
- R5: A plain write (req_write=1, req_locked=0) always gets wr_pass=1. It removes the reservation of every context on its granule.
- R6: A store-conditional passes only if the requesting context's own entry is valid and holds the write's granule. A reservation held by another context does not make it pass.
- R7: Several contexts may reserve the same granule. Any write to it, whether plain, a passing store-conditional or a failing one, clears all of those reservations in the same cycle.
- R8: One cycle after a store-conditional, sc_resp_valid=1 and sc_resp_pass reports 1 for pass or 0 for fail. Plain writes and reads give sc_resp_valid=0.
- R9: Plain reads (req_locked=0) leave the reservation table unchanged.
- R10: wr_pass is the memory write gate. It follows the request in the same cycle, and it is 0 for reads and whenever req_valid=0. A request with req_valid=0 does not change the table.
- R11: A write to a granule that no entry matches leaves every reservation intact. This includes a failing store-conditional whose own reservation lies on another granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_ctx | input | CTX_W | Requesting context ID |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_locked | input | 1 | Locked flag: locked read or store-conditional |
| wr_pass | output | 1 | Write may update memory (combinational gate) |
| sc_resp_valid | output | 1 | Registered: previous request was a store-conditional |
| sc_resp_pass | output | 1 | Registered store-conditional result, 1 = pass |

## Verification
The assertions check the following on every cycle:
- A plain write always passes, and a read or an idle cycle never does.
- A passing store-conditional always has a valid entry for its own context.
- The cycle after any write that matches an entry, that entry is empty.
- After a locked read, the issuer's entry holds the new granule.
- A cycle with no table operation leaves every valid bit as it was.

Some behaviours need a sequence of requests and only the bench's scenarios can show them:
- A reservation that moves, so the old granule fails.
- A foreign store-conditional that wipes a shared reservation.
- A failing store-conditional that leaves the requester's reservation on another granule untouched.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,  // idle or plain read: no table effect
    OP_LRD  = 2'd1,  // locked read: place or move reservation
    OP_PWR  = 2'd2,  // plain write
    OP_SCW  = 2'd3   // store-conditional
  } op_e;

  function automatic op_e decode_op(input logic v, input logic w, input logic l);
    if (!v)     return OP_NONE;
    else if (w) return l ? OP_SCW : OP_PWR;
    else        return l ? OP_LRD : OP_NONE;
  endfunction

endpackage

// File: rtl/lrsc_entry.sv
module lrsc_entry
  import lrsc_pkg::*;
#(
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op_i,
  input  logic             own_i,
  input  logic [TAG_W-1:0] gran_i,
  output logic             valid_o,
  output logic             match_o
);

  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  assign match_o = valid_q && (tag_q == gran_i);
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else begin
      unique case (op_i)
        OP_LRD:         if (own_i)   valid_q <= 1'b1;
        OP_PWR, OP_SCW: if (match_o) valid_q <= 1'b0;
        default:        ;
      endcase
    end
  end

  // tag storage carries no reset; it is only read when valid_q is set
  always_ff @(posedge clk) begin
    if (op_i == OP_LRD && own_i) tag_q <= gran_i;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !valid_q);

  a_r3_locked_read_loads: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LRD && own_i) |=> (valid_q && tag_q == $past(gran_i)));

  a_r7_write_clears_match: assert property (@(posedge clk) disable iff (rst)
    ((op_i == OP_PWR || op_i == OP_SCW) && match_o) |=> !valid_q);

  a_r9_idle_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NONE) |=> (valid_q == $past(valid_q)));

endmodule

// File: rtl/lrsc_verdict.sv
module lrsc_verdict
  import lrsc_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  op_e                op_i,
  input  logic [CTX_W-1:0]   ctx_i,
  input  logic [NUM_CTX-1:0] match_vec_i,
  output logic               sc_hit_o,
  output logic               pass_o
);

  // a store-conditional begins as a failure and is rescued only by its own entry
  always_comb begin
    sc_hit_o = 1'b0;
    if (op_i == OP_SCW) sc_hit_o = match_vec_i[ctx_i];
    pass_o = (op_i == OP_PWR) || sc_hit_o;
  end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int NUM_CTX  = 4,
  parameter int ADDR_W   = 16,
  parameter int GRAN_LSB = 3,
  localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_locked,
  output logic              wr_pass,
  output logic              sc_resp_valid,
  output logic              sc_resp_pass
);

  op_e                op;
  logic [TAG_W-1:0]   gran;
  logic [NUM_CTX-1:0] ent_valid;
  logic [NUM_CTX-1:0] ent_match;
  logic               sc_hit;
  logic               unused_lsb;

  assign op         = decode_op(req_valid, req_write, req_locked);
  assign gran       = req_addr[ADDR_W-1:GRAN_LSB];
  assign unused_lsb = ^req_addr[GRAN_LSB-1:0];

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ent
    lrsc_entry #(.TAG_W(TAG_W)) u_ent (
      .clk     (clk),
      .rst     (rst),
      .op_i    (op),
      .own_i   (req_ctx == CTX_W'(i)),
      .gran_i  (gran),
      .valid_o (ent_valid[i]),
      .match_o (ent_match[i])
    );
  end

  lrsc_verdict #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_verdict (
    .op_i        (op),
    .ctx_i       (req_ctx),
    .match_vec_i (ent_match),
    .sc_hit_o    (sc_hit),
    .pass_o      (wr_pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_resp_valid <= 1'b0;
      sc_resp_pass  <= 1'b0;
    end else begin
      sc_resp_valid <= (op == OP_SCW);
      sc_resp_pass  <= sc_hit;
    end
  end

  a_r5_plain_write_passes: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_locked) |-> wr_pass);

  a_r6_sc_needs_own_entry: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_locked && wr_pass) |-> ent_valid[req_ctx]);

  a_r10_no_gate_on_read: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |-> !wr_pass);

  a_r8_resp_follows_sc: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sc_resp_valid == $past(req_valid && req_write && req_locked)));

  a_r8_pass_implies_valid: assert property (@(posedge clk) disable iff (rst)
    sc_resp_pass |-> sc_resp_valid);

endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;

  localparam int NC = 4;
  localparam int AW = 16;
  localparam int GL = 3;
  localparam int CW = 2;
  localparam int TW = AW - GL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [CW-1:0] req_ctx = '0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          req_locked = 1'b0;
  logic          wr_pass, sc_resp_valid, sc_resp_pass;

  int checks = 0;
  int fails  = 0;

  bit          mvalid [NC];
  logic [TW-1:0] mtag [NC];

  always #4 clk = ~clk;

  lrsc_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_LSB(GL)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ctx(req_ctx),
    .req_addr(req_addr), .req_write(req_write), .req_locked(req_locked),
    .wr_pass(wr_pass), .sc_resp_valid(sc_resp_valid), .sc_resp_pass(sc_resp_pass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_pass(int c, logic [AW-1:0] a, bit v, bit w, bit l);
    if (!v || !w) return 1'b0;
    if (!l) return 1'b1;
    return mvalid[c] && (mtag[c] == a[AW-1:GL]);
  endfunction

  task automatic model_update(int c, logic [AW-1:0] a, bit v, bit w, bit l);
    if (!v) return;
    if (!w && l) begin
      mvalid[c] = 1'b1;
      mtag[c]   = a[AW-1:GL];
    end else if (w) begin
      for (int i = 0; i < NC; i++)
        if (mvalid[i] && mtag[i] == a[AW-1:GL]) mvalid[i] = 1'b0;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NC; i++) mvalid[i] = 1'b0;
  endtask

  // one request per cycle: gate checked combinationally, response after the edge
  task automatic op(input int c, input logic [AW-1:0] a, input bit v, input bit w,
                    input bit l, input string tag, output bit got);
    bit ep;
    @(negedge clk);
    req_valid = v; req_ctx = CW'(c); req_addr = a; req_write = w; req_locked = l;
    #1;
    ep  = exp_pass(c, a, v, w, l);
    got = wr_pass;
    chk({tag, " wr_pass"}, 32'(wr_pass), 32'(ep));
    @(posedge clk);
    #1;
    chk({tag, " sc_resp_valid"}, 32'(sc_resp_valid), 32'(v && w && l));
    chk({tag, " sc_resp_pass"}, 32'(sc_resp_pass), 32'(v && w && l && ep));
    model_update(c, a, v, w, l);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset sc_resp_valid", 32'(sc_resp_valid), 32'd0);
    chk("R1 reset wr_pass", 32'(wr_pass), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  bit done = 1'b0;

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected completion");
      finish_run();
    end
  end

  localparam logic [AW-1:0] A = 16'h0100;
  localparam logic [AW-1:0] B = 16'h0240;

  initial begin
    bit g;
    void'($urandom(32'd20240611));
    model_clear();
    do_reset();

    // R1: reservation lost across reset
    op(0, A, 1, 0, 1, "R1 reserve", g);
    do_reset();
    op(0, A, 1, 1, 1, "R1 sc after reset", g);
    chk("R1 sc after reset fails", 32'(g), 32'd0);

    // R2: basic pair
    op(1, A, 1, 0, 1, "R2 reserve", g);
    op(1, A, 1, 1, 1, "R2 sc", g);
    chk("R2 sc passes", 32'(g), 32'd1);

    // R3 / R11: moving reservation; failed sc elsewhere keeps it
    op(2, A, 1, 0, 1, "R3 reserve A", g);
    op(2, B, 1, 0, 1, "R3 move to B", g);
    op(2, A, 1, 1, 1, "R3 sc old", g);
    chk("R3 sc old granule fails", 32'(g), 32'd0);
    op(2, B, 1, 1, 1, "R11 sc moved", g);
    chk("R11 reservation survives failed sc", 32'(g), 32'd1);

    // R4: granule masking
    op(3, A + 1, 1, 0, 1, "R4 reserve", g);
    op(3, A + 8, 1, 1, 1, "R4 next granule", g);
    chk("R4 next granule fails", 32'(g), 32'd0);
    op(3, A + 7, 1, 1, 1, "R4 same granule", g);
    chk("R4 same granule passes", 32'(g), 32'd1);

    // R5 / R7 / R8: plain write wipes shared reservations
    op(0, A, 1, 0, 1, "R7 reserve c0", g);
    op(1, A + 2, 1, 0, 1, "R7 reserve c1", g);
    op(2, A + 3, 1, 1, 0, "R5 plain write", g);
    chk("R5 plain write passes", 32'(g), 32'd1);
    op(0, A, 1, 1, 1, "R7 sc c0", g);
    chk("R7 c0 cleared", 32'(g), 32'd0);
    op(1, A, 1, 1, 1, "R7 sc c1", g);
    chk("R7 c1 cleared", 32'(g), 32'd0);

    // R6 / R7: foreign sc fails and still clears the owner
    op(0, B, 1, 0, 1, "R6 reserve c0", g);
    op(1, B, 1, 1, 1, "R6 foreign sc", g);
    chk("R6 foreign sc fails", 32'(g), 32'd0);
    op(0, B, 1, 1, 1, "R7 owner after foreign sc", g);
    chk("R7 owner cleared by failed sc", 32'(g), 32'd0);

    // R9: plain reads do nothing
    op(1, A, 1, 0, 1, "R9 reserve", g);
    op(1, B, 1, 0, 0, "R9 plain read own", g);
    op(0, A, 1, 0, 0, "R9 plain read other", g);
    op(1, A, 1, 1, 1, "R9 sc", g);
    chk("R9 reservation intact", 32'(g), 32'd1);

    // R10: invalid requests are ignored
    op(2, A, 1, 0, 1, "R10 reserve", g);
    op(2, A, 0, 1, 1, "R10 idle sc", g);
    chk("R10 idle gate low", 32'(g), 32'd0);
    op(3, A, 0, 1, 0, "R10 idle write", g);
    op(2, A, 1, 1, 1, "R10 sc", g);
    chk("R10 reservation intact", 32'(g), 32'd1);

    // random mix against the model (R2 R5 R6 R7 R9 R10)
    for (int n = 0; n < 3000; n++) begin
      int c = int'($urandom % NC);
      logic [AW-1:0] a = A + AW'(($urandom % 4) * 8) + AW'($urandom % 8);
      int k = int'($urandom % 10);
      bit v = (k != 0);
      bit w = (k >= 5);
      bit l = (k < 4) || (k >= 7);
      op(c, a, v, w, l, "R6 R7 random", g);
    end

    done = 1'b1;
    finish_run();
  end

endmodule